// File: doc/BRIEF.md
# PS/2 Mouse Movement Report Assembler

This block listens to the two-wire serial link of a PS/2 mouse (clock and data, both idle high) and turns each group of three received frames into one movement report. The first frame of a group carries the button and sign/overflow bits. The second carries the horizontal magnitude and the third the vertical magnitude. The block outputs the two button states, two 9-bit signed deltas, two overflow flags and a single-cycle strobe marking a fresh report.

Both wires are brought into the system clock domain through a short synchronizer chain. Bits are taken on each falling edge of the mouse clock. Each completed frame is checked for its start bit, stop bit and odd parity. A frame that fails any check raises a one-cycle error strobe and throws away the partial report. A first frame whose fixed marker bit is clear is treated as misalignment and dropped without comment. A long silence on the mouse clock abandons any partial frame or report, so the block always restarts cleanly at a status frame.

Top module: `mouse_pkt_asm`

## Requirements
- R1: After reset, all report outputs are 0 and neither strobe is asserted.
- R2: A frame is 11 bits sampled on mouse-clock falling edges: a 0 start bit, 8 data bits least significant first, a parity bit that makes the count of ones in data plus parity odd, and a 1 stop bit.
- R3: In the status byte, bit 0 is the left button and bit 1 the right button (1 = held), bit 4 is the X sign, bit 5 the Y sign, bit 6 the X overflow and bit 7 the Y overflow.
- R4: Each delta is the 9-bit two's-complement value {sign bit, magnitude byte}, where a sign of 1 marks a negative value.
- R5: Each valid three-frame packet produces exactly one single-cycle reportValid pulse. The report outputs change only in that cycle and hold their values otherwise.
- R6: A frame with wrong parity raises errStrobe for one cycle, produces no report, and makes the next frame be taken as a status byte.
- R7: A frame with a start bit of 1 or a stop bit of 0 is handled like a parity error.
- R8: A frame received while a status byte is expected, whose bit 3 is 0, is discarded with no strobe, and the frame after it is again taken as a status byte.
- R9: If more than GAP_CYCLES system clocks pass with no mouse-clock falling edge, any partly received frame and packet are abandoned.
- R10: An error in the X or Y frame drops the whole packet and leaves the previous report on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2Clk | input | 1 | Mouse clock line, asynchronous |
| ps2Data | input | 1 | Mouse data line, asynchronous |
| leftBtn | output | 1 | Left button held |
| rightBtn | output | 1 | Right button held |
| xDelta | output | 9 | Signed horizontal movement |
| yDelta | output | 9 | Signed vertical movement |
| xOvf | output | 1 | Horizontal overflow flag |
| yOvf | output | 1 | Vertical overflow flag |
| reportValid | output | 1 | One-cycle pulse: new report on outputs |
| errStrobe | output | 1 | One-cycle pulse: a frame failed its checks |

## Verification
The assertions assume that consecutive mouse-clock falling edges are many system clocks apart, at least several times the synchronizer depth. This lets a completed frame be checked and retired before the next bit can arrive. They also assume the data line is steady around each falling edge. The stimulus holds the mouse clock low and high for 40 system clocks each. It changes data only while the clock is high, and it leaves inter-frame gaps far below GAP_CYCLES except where a stall is wanted on purpose. In that case it waits for twice GAP_CYCLES.

// File: rtl/mouse_pkg.sv
package mouse_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 3;
  localparam int DELTA_W    = DATA_BITS + 1;
  localparam int PKT_BYTES  = 3;

  // status byte field positions (decoded by the datapath)
  localparam int ST_LEFT   = 0;
  localparam int ST_RIGHT  = 1;
  localparam int ST_MARK   = 3;
  localparam int ST_XSIGN  = 4;
  localparam int ST_YSIGN  = 5;
  localparam int ST_XOVF   = 6;
  localparam int ST_YOVF   = 7;

  typedef struct packed {
    logic shift;      // falling edge seen: shift in one bit
    logic capStatus;  // good status frame: latch it
    logic capX;       // good X frame: latch it
    logic emit;       // good Y frame: publish report
  } ctlStrobes_t;
endpackage

// File: rtl/mouse_line_sync.sv
module mouse_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g] <= '1;
      else if (g == 0) stage[g] <= din;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/mouse_pkt_ctrl.sv
module mouse_pkt_ctrl
  import mouse_pkg::*;
#(
  parameter int GAP_CYCLES = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clkS,
  input  logic        frameOk,
  input  logic        statusMarker,
  output ctlStrobes_t ctl,
  output logic        errPulse
);
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam int IDX_W  = $clog2(PKT_BYTES);
  localparam int IDLE_W = $clog2(GAP_CYCLES + 1);

  logic              prevClk;
  logic              fall;
  logic [BIT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              frameDone;
  logic [IDX_W-1:0]  byteIdx;
  logic              gapHit;

  assign fall   = prevClk & ~clkS;
  assign gapHit = (idleCnt >= IDLE_W'(GAP_CYCLES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevClk   <= 1'b1;
      bitCnt    <= '0;
      idleCnt   <= '0;
      frameDone <= 1'b0;
      byteIdx   <= '0;
      errPulse  <= 1'b0;
    end else begin
      prevClk   <= clkS;
      frameDone <= 1'b0;
      errPulse  <= 1'b0;
      if (fall) begin
        idleCnt <= '0;
        if (bitCnt == BIT_W'(FRAME_BITS-1)) begin
          bitCnt    <= '0;
          frameDone <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (!gapHit) begin
        idleCnt <= idleCnt + 1'b1;
      end else begin
        bitCnt  <= '0;
        byteIdx <= '0;
      end

      if (frameDone) begin
        if (!frameOk) begin
          errPulse <= 1'b1;
          byteIdx  <= '0;
        end else if (byteIdx == '0) begin
          if (statusMarker) byteIdx <= IDX_W'(1);
        end else if (byteIdx == IDX_W'(PKT_BYTES-2)) begin
          byteIdx <= IDX_W'(PKT_BYTES-1);
        end else begin
          byteIdx <= '0;
        end
      end
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.shift     = fall;
    ctl.capStatus = frameDone & frameOk & (byteIdx == '0) & statusMarker;
    ctl.capX      = frameDone & frameOk & (byteIdx == IDX_W'(PKT_BYTES-2));
    ctl.emit      = frameDone & frameOk & (byteIdx == IDX_W'(PKT_BYTES-1));
  end

  // R5: packet position never leaves the three-byte range
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byteIdx <= IDX_W'(PKT_BYTES-1));

  // R9: a silent mouse clock clears partial frame and packet
  p_gap_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gapHit && !fall) |=> (bitCnt == '0 && byteIdx == '0));

  // R6: a bad frame never also advances to a report
  p_err_no_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frameDone && !frameOk) |=> (byteIdx == '0 && errPulse));
endmodule

// File: rtl/mouse_pkt_dp.sv
module mouse_pkt_dp
  import mouse_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dataS,
  input  ctlStrobes_t        ctl,
  output logic               frameOk,
  output logic               statusMarker,
  output logic               leftBtn,
  output logic               rightBtn,
  output logic [DELTA_W-1:0] xDelta,
  output logic [DELTA_W-1:0] yDelta,
  output logic               xOvf,
  output logic               yOvf,
  output logic               reportValid
);
  logic [FRAME_BITS-1:0] shreg;
  logic [DATA_BITS-1:0]  frameByte;
  logic [DATA_BITS-1:0]  statusReg;
  logic [DATA_BITS-1:0]  xReg;

  // after a full frame: [0]=start, [DATA_BITS:1]=data, [DATA_BITS+1]=parity, top=stop
  assign frameByte    = shreg[DATA_BITS:1];
  assign frameOk      = ~shreg[0] & shreg[FRAME_BITS-1] & (^shreg[DATA_BITS+1:1]);
  assign statusMarker = frameByte[ST_MARK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg       <= '1;
      statusReg   <= '0;
      xReg        <= '0;
      leftBtn     <= 1'b0;
      rightBtn    <= 1'b0;
      xDelta      <= '0;
      yDelta      <= '0;
      xOvf        <= 1'b0;
      yOvf        <= 1'b0;
      reportValid <= 1'b0;
    end else begin
      reportValid <= ctl.emit;
      if (ctl.shift)     shreg     <= {dataS, shreg[FRAME_BITS-1:1]};
      if (ctl.capStatus) statusReg <= frameByte;
      if (ctl.capX)      xReg      <= frameByte;
      if (ctl.emit) begin
        leftBtn  <= statusReg[ST_LEFT];
        rightBtn <= statusReg[ST_RIGHT];
        xDelta   <= {statusReg[ST_XSIGN], xReg};
        yDelta   <= {statusReg[ST_YSIGN], frameByte};
        xOvf     <= statusReg[ST_XOVF];
        yOvf     <= statusReg[ST_YOVF];
      end
    end
  end

  // R8: a status byte is only latched when its marker bit is set
  p_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capStatus |-> shreg[ST_MARK+1]);

  // R5: the report strobe lasts exactly one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reportValid |=> !reportValid);

  // R5: report outputs hold between reports
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.emit |=> ($stable(xDelta) && $stable(yDelta) && $stable(leftBtn) && $stable(rightBtn)));
endmodule

// File: rtl/mouse_pkt_asm.sv
module mouse_pkt_asm
  import mouse_pkg::*;
#(
  parameter int GAP_CYCLES  = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2Clk,
  input  logic       ps2Data,
  output logic       leftBtn,
  output logic       rightBtn,
  output logic [8:0] xDelta,
  output logic [8:0] yDelta,
  output logic       xOvf,
  output logic       yOvf,
  output logic       reportValid,
  output logic       errStrobe
);
  logic [1:0]  lineS;
  ctlStrobes_t ctl;
  logic        frameOk;
  logic        statusMarker;

  mouse_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ps2Clk, ps2Data}), .dout(lineS)
  );

  mouse_pkt_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkS(lineS[1]), .frameOk(frameOk),
    .statusMarker(statusMarker), .ctl(ctl), .errPulse(errStrobe)
  );

  mouse_pkt_dp u_dp (
    .clk(clk), .rst_n(rst_n), .dataS(lineS[0]), .ctl(ctl),
    .frameOk(frameOk), .statusMarker(statusMarker),
    .leftBtn(leftBtn), .rightBtn(rightBtn), .xDelta(xDelta), .yDelta(yDelta),
    .xOvf(xOvf), .yOvf(yOvf), .reportValid(reportValid)
  );

  // R6: report and error strobes never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reportValid && errStrobe));
endmodule

// File: tb/mouse_pkt_asm_bench.sv
module mouse_pkt_asm_bench;
  localparam int GAP  = 1000;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps2Clk = 1'b1;
  logic ps2Data = 1'b1;
  logic leftBtn, rightBtn, xOvf, yOvf, reportValid, errStrobe;
  logic [8:0] xDelta, yDelta;

  always #2 clk = ~clk;

  mouse_pkt_asm #(.GAP_CYCLES(GAP)) u_mouse_pkt_asm (
    .clk(clk), .rst_n(rst_n), .ps2Clk(ps2Clk), .ps2Data(ps2Data),
    .leftBtn(leftBtn), .rightBtn(rightBtn), .xDelta(xDelta), .yDelta(yDelta),
    .xOvf(xOvf), .yOvf(yOvf), .reportValid(reportValid), .errStrobe(errStrobe)
  );

  typedef struct {
    logic       isErr;
    logic       l, r, xo, yo;
    logic [8:0] x, y;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  logic prevValid = 1'b0;
  logic [8:0] lastX = '0, lastY = '0;
  logic lastL = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sendBit(input logic b);
    ps2Data = b;
    waitClk(HALF);
    ps2Clk = 1'b0;
    waitClk(HALF);
    ps2Clk = 1'b1;
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic flipPar,
                           input logic badStop, input logic badStart);
    sendBit(badStart);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    sendBit((~^b) ^ flipPar);
    sendBit(~badStop);
    ps2Data = 1'b1;
    waitClk(200);
  endtask

  task automatic expectReport(input logic [7:0] st, input logic [7:0] x,
                              input logic [7:0] y, input string tag);
    item_t it;
    it.isErr = 1'b0;
    it.l = st[0]; it.r = st[1]; it.xo = st[6]; it.yo = st[7];
    it.x = {st[4], x}; it.y = {st[5], y};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expectErr(input string tag);
    item_t it;
    it = '{isErr: 1'b1, l: 1'b0, r: 1'b0, xo: 1'b0, yo: 1'b0, x: '0, y: '0, tag: tag};
    q.push_back(it);
  endtask

  task automatic sendPacket(input logic [7:0] st, input logic [7:0] x,
                            input logic [7:0] y, input string tag);
    expectReport(st, x, y, tag);
    sendFrame(st, 0, 0, 0);
    sendFrame(x, 0, 0, 0);
    sendFrame(y, 0, 0, 0);
  endtask

  // monitor: pops expected items as the design produces strobes
  always @(negedge clk) begin
    if (rst_n) begin
      if (reportValid && prevValid) begin
        checks++; fails++;
        $display("FAIL R5: actual valid high two cycles expected one");
      end
      if (reportValid || errStrobe) begin
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5: actual unexpected strobe valid=%0b err=%0b expected none",
                   reportValid, errStrobe);
        end else begin
          item_t it;
          it = q.pop_front();
          if (it.isErr) begin
            chk({it.tag, " errStrobe"}, {31'b0, errStrobe}, 32'd1);
          end else begin
            chk({it.tag, " valid"}, {31'b0, reportValid}, 32'd1);
            chk({it.tag, " R3 buttons"}, {30'b0, leftBtn, rightBtn}, {30'b0, it.l, it.r});
            chk({it.tag, " R3 ovf"}, {30'b0, xOvf, yOvf}, {30'b0, it.xo, it.yo});
            chk({it.tag, " R4 xDelta"}, {23'b0, xDelta}, {23'b0, it.x});
            chk({it.tag, " R4 yDelta"}, {23'b0, yDelta}, {23'b0, it.y});
            lastX = it.x; lastY = it.y; lastL = it.l;
          end
        end
      end
      prevValid <= reportValid;
    end
  end

  task automatic checkHeld(input string tag);
    @(negedge clk);
    chk({tag, " held xDelta"}, {23'b0, xDelta}, {23'b0, lastX});
    chk({tag, " held yDelta"}, {23'b0, yDelta}, {23'b0, lastY});
    chk({tag, " held left"}, {31'b0, leftBtn}, {31'b0, lastL});
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    waitClk(190000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    waitClk(5);
    @(negedge clk);
    // R1: reset state
    chk("R1 xDelta", {23'b0, xDelta}, 32'd0);
    chk("R1 yDelta", {23'b0, yDelta}, 32'd0);
    chk("R1 strobes", {30'b0, reportValid, errStrobe}, 32'd0);
    chk("R1 buttons", {28'b0, leftBtn, rightBtn, xOvf, yOvf}, 32'd0);
    rst_n = 1'b1;
    waitClk(20);

    // R2 R3 R4: plain packets
    sendPacket(8'h09, 8'h05, 8'h10, "R2 left positive");
    sendPacket(8'h3A, 8'hFB, 8'h80, "R4 right negative");
    sendPacket(8'hC8, 8'hFF, 8'h00, "R3 overflow");

    // R6: parity error on status frame
    expectErr("R6 status parity");
    sendFrame(8'h09, 1, 0, 0);
    checkHeld("R6");

    // R10: parity error on Y frame drops packet
    sendFrame(8'h19, 0, 0, 0);
    sendFrame(8'h22, 0, 0, 0);
    expectErr("R10 Y parity");
    sendFrame(8'h33, 1, 0, 0);
    checkHeld("R10");

    // R7: bad stop on X frame, then bad start on status
    sendFrame(8'h08, 0, 0, 0);
    expectErr("R7 X stop");
    sendFrame(8'h44, 0, 1, 0);
    expectErr("R7 status start");
    sendFrame(8'h08, 0, 0, 1);
    checkHeld("R7");
    sendPacket(8'h0A, 8'h12, 8'h34, "R7 recovery");

    // R8: misaligned first byte discarded
    sendFrame(8'h05, 0, 0, 0);
    checkHeld("R8");
    sendPacket(8'h1B, 8'h01, 8'h02, "R8 realign");

    // R9: stall between frames of a packet
    sendFrame(8'h09, 0, 0, 0);
    sendFrame(8'h55, 0, 0, 0);
    waitClk(2*GAP);
    sendPacket(8'h28, 8'h7F, 8'h81, "R9 packet gap");

    // R9: stall inside a frame
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    ps2Data = 1'b1;
    waitClk(2*GAP);
    sendPacket(8'h39, 8'h80, 8'hFE, "R9 bit gap");

    waitClk(100);
    chk("R5 queue drained", q.size(), 32'd0);
    finishRun();
  end
endmodule